// File: doc/BRIEF.md
# Two-Key Register Access Lock

This block guards an indirect register port. Before a host may touch the port's address and data registers, it must write two fixed byte values, in a fixed order, to a dedicated key register. Once both keys are accepted, the `unlocked` flag rises. The access bridge in front of the protected registers then lets reads and writes through, for as many accesses as the host needs.

Some events are treated as tampering or a software fault: a wrong key value, the right keys in the wrong order, or an attempt to reach the address or data registers while still locked. Any of these drives the block into a disabled state, and only a reset leaves that state. On entry to the disabled state, a one-cycle violation strobe fires. While the port is open, any write to the key register closes it again. The host can read the key register at any time to get a two-bit status code. Reading never disturbs a sequence in progress.

Top module: `keylock_guard`

## Requirements
- R1: After reset the status code is 0 (locked, waiting for the first key), and `unlocked`, `disabled` and `violation` are all 0.
- R2: In status 0, a key write of 0xA5 moves the status to 1 (first key accepted) on the following cycle.
- R3: In status 1, a key write of 0xF1 moves the status to 2 and raises `unlocked` on the following cycle.
- R4: Any number of idle cycles and status reads between the first and second key writes has no effect on acceptance.
- R5: In status 0 or 1, a key write of any value other than the one expected in that state moves the status to 3 and raises `disabled` on the following cycle. This includes 0xF1 written first and 0xA5 written twice.
- R6: In status 0 or 1, an access attempt (`acc_rd` or `acc_wr` high) moves the status to 3 on the following cycle, even when a key write arrives in the same cycle.
- R7: In status 3, key writes and access attempts have no effect; status 3 and `disabled` persist until reset.
- R8: In status 2, any number of access attempts leaves the status at 2 and `unlocked` high.
- R9: In status 2, a key write of any value returns the status to 0 and drops `unlocked` on the following cycle.
- R10: While `key_rd` is high, `key_rdata` holds the status code in bits [1:0] and zeros above, in the same cycle; with `key_rd` low it reads 0. Reads never change the state.
- R11: `violation` is high for exactly one cycle, the first cycle in which `disabled` is high.
- R12: `unlocked` and `disabled` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr | input | 1 | Write strobe for the key register |
| key_wdata | input | 8 | Byte written to the key register |
| key_rd | input | 1 | Read strobe for the key register |
| key_rdata | output | 8 | Status readback, code in bits [1:0] |
| acc_rd | input | 1 | Host attempts to read the address or data register |
| acc_wr | input | 1 | Host attempts to write the address or data register |
| unlocked | output | 1 | Protected registers are accessible |
| disabled | output | 1 | Port is disabled until reset |
| violation | output | 1 | One-cycle strobe on entry to the disabled state |

## Verification
A wrong internal state shows at the ports within one clock edge. It appears as a status code on the next key read that differs from the model, as an `unlocked` flag that differs from the model, or as a missing or extra `violation` pulse. The bench compares every output against a behavioural model after every edge, so a bad transition is reported in the cycle it happens. The stimulus covers every state-changing event in each state, including the tie between a key write and an access in the same cycle.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

   typedef enum logic [1:0] {
      KL_LOCKED = 2'd0,
      KL_HALF   = 2'd1,
      KL_OPEN   = 2'd2,
      KL_DEAD   = 2'd3
   } kl_state_e;

   localparam int unsigned KL_CODE_W = 2;

endpackage

// File: rtl/keylock_match.sv
module keylock_match #(
   parameter int unsigned   KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hA5,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1
) (
   input  logic [KEY_W-1:0] wdata,
   output logic             hit_first,
   output logic             hit_second
);

   assign hit_first  = (wdata == KEY_FIRST);
   assign hit_second = (wdata == KEY_SECOND);

endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
   import keylock_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      key_wr,
   input  logic      hit_first,
   input  logic      hit_second,
   input  logic      access,
   output kl_state_e state,
   output logic      violation
);

   kl_state_e state_q, state_d;
   logic      viol_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         KL_LOCKED: begin
            if (access)      state_d = KL_DEAD;
            else if (key_wr) state_d = hit_first ? KL_HALF : KL_DEAD;
         end
         KL_HALF: begin
            if (access)      state_d = KL_DEAD;
            else if (key_wr) state_d = hit_second ? KL_OPEN : KL_DEAD;
         end
         KL_OPEN: begin
            if (key_wr)      state_d = KL_LOCKED;
         end
         default:            state_d = KL_DEAD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= KL_LOCKED;
         viol_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         viol_q  <= (state_d == KL_DEAD) && (state_q != KL_DEAD);
      end
   end

   assign state     = state_q;
   assign violation = viol_q;

   // R7: once disabled, stays disabled
   a_r7_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == KL_DEAD |=> state_q == KL_DEAD);

   // R11: strobe only on the first disabled cycle
   a_r11_strobe_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      viol_q |-> state_q == KL_DEAD && $past(state_q) != KL_DEAD);

   a_r11_entry_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != KL_DEAD ##1 state_q == KL_DEAD |-> viol_q);

   // R6: access while locked disables
   a_r6_access_kills: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KL_LOCKED || state_q == KL_HALF) && access |=> state_q == KL_DEAD);

   // R8: open port survives accesses
   a_r8_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == KL_OPEN && !key_wr |=> state_q == KL_OPEN);

   // R9: key write while open relocks
   a_r9_relock: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == KL_OPEN && key_wr |=> state_q == KL_LOCKED);

   // R3: unlock only through the half state
   a_r3_open_path: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != KL_OPEN ##1 state_q == KL_OPEN |-> $past(state_q) == KL_HALF);

endmodule

// File: rtl/keylock_readback.sv
module keylock_readback
   import keylock_pkg::*;
#(
   parameter int unsigned STAT_W  = 8,
   parameter bit          RD_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  kl_state_e         state,
   output logic [STAT_W-1:0] rdata
);

   logic [STAT_W-1:0] code;
   assign code = STAT_W'(state);

   generate
      if (RD_REG) begin : g_reg
         logic [STAT_W-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  hold_q <= '0;
            else if (rd) hold_q <= code;
         end
         assign rdata = hold_q;
      end else begin : g_comb
         assign rdata = rd ? code : '0;
         // R10: status visible in the read cycle, upper bits zero
         a_r10_read_code: assert property (@(posedge clk) disable iff (!rst_n)
            rd |-> rdata[STAT_W-1:KL_CODE_W] == '0);
      end
   endgenerate

endmodule

// File: rtl/keylock_guard.sv
module keylock_guard
   import keylock_pkg::*;
#(
   parameter int unsigned      KEY_W      = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hA5,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1,
   parameter int unsigned      STAT_W     = 8,
   parameter bit               RD_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [KEY_W-1:0]  key_wdata,
   input  logic              key_rd,
   output logic [STAT_W-1:0] key_rdata,
   input  logic              acc_rd,
   input  logic              acc_wr,
   output logic              unlocked,
   output logic              disabled,
   output logic              violation
);

   generate
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
         $error("keylock_guard: the two keys must differ");
      end
      if (STAT_W <= KL_CODE_W) begin : g_bad_stat
         $error("keylock_guard: STAT_W must exceed the code width");
      end
   endgenerate

   logic      hit_first, hit_second;
   kl_state_e state;

   keylock_match #(
      .KEY_W     (KEY_W),
      .KEY_FIRST (KEY_FIRST),
      .KEY_SECOND(KEY_SECOND)
   ) u_match (
      .wdata     (key_wdata),
      .hit_first (hit_first),
      .hit_second(hit_second)
   );

   keylock_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_wr    (key_wr),
      .hit_first (hit_first),
      .hit_second(hit_second),
      .access    (acc_rd | acc_wr),
      .state     (state),
      .violation (violation)
   );

   keylock_readback #(
      .STAT_W(STAT_W),
      .RD_REG(RD_REG)
   ) u_rb (
      .clk  (clk),
      .rst_n(rst_n),
      .rd   (key_rd),
      .state(state),
      .rdata(key_rdata)
   );

   assign unlocked = (state == KL_OPEN);
   assign disabled = (state == KL_DEAD);

   // R12: flags are exclusive
   a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(unlocked && disabled));

   // R5: wrong key while waiting for the first key disables
   a_r5_wrong_first: assert property (@(posedge clk) disable iff (!rst_n)
      state == KL_LOCKED && key_wr && key_wdata != KEY_FIRST |=> disabled);

endmodule

// File: tb/tb_keylock_guard.sv
module tb_keylock_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_wr = 1'b0;
   logic [7:0] key_wdata = 8'h00;
   logic       key_rd = 1'b0;
   logic [7:0] key_rdata;
   logic       acc_rd = 1'b0;
   logic       acc_wr = 1'b0;
   logic       unlocked, disabled, violation;

   int n_checks = 0;
   int n_fail   = 0;
   int m_st     = 0;
   int m_viol   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   keylock_guard dut (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_wdata(key_wdata),
      .key_rd(key_rd), .key_rdata(key_rdata), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .unlocked(unlocked), .disabled(disabled), .violation(violation)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_outs(string req);
      chk(req, "unlocked", int'(unlocked), (m_st == 2) ? 1 : 0);
      chk(req, "disabled", int'(disabled), (m_st == 3) ? 1 : 0);
      chk(req, "violation", int'(violation), m_viol);
      chk("R12", "exclusive", int'(unlocked & disabled), 0);
   endtask

   // one clock: drive at negedge, model update at posedge, compare after
   task automatic step(string req, bit kw, logic [7:0] kd, bit rd, bit ar, bit aw);
      bit acc;
      int nx;
      key_wr = kw; key_wdata = kd; key_rd = rd; acc_rd = ar; acc_wr = aw;
      #1;
      chk("R10", "rdata", int'(key_rdata), rd ? m_st : 0);
      @(posedge clk);
      acc = ar | aw;
      nx = m_st;
      if (m_st == 2) begin
         if (kw) nx = 0;
      end else if (m_st != 3) begin
         if (acc) nx = 3;
         else if (kw) begin
            if (m_st == 0) nx = (kd == 8'hA5) ? 1 : 3;
            else           nx = (kd == 8'hF1) ? 2 : 3;
         end
      end
      m_viol = (nx == 3 && m_st != 3) ? 1 : 0;
      m_st = nx;
      @(negedge clk);
      key_wr = 1'b0; key_rd = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
      check_outs(req);
   endtask

   task automatic idle(string req, int n);
      for (int i = 0; i < n; i++) step(req, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic status(string req);
      step(req, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_st = 0; m_viol = 0;
      check_outs("R1");
      status("R1");
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R2 R3 R4 R10: slow sequence with reads in between
      step("R2", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      status("R2");
      idle("R4", 7);
      status("R4");
      step("R3", 1'b1, 8'hF1, 1'b0, 1'b0, 1'b0);
      status("R3");
      // R8: many accesses keep the port open
      for (int i = 0; i < 6; i++) step("R8", 1'b0, 8'h00, 1'b0, i[0], ~i[0]);
      step("R8", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
      status("R8");
      // R9: any key write relocks
      step("R9", 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0);
      status("R9");
      step("R2", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      step("R3", 1'b1, 8'hF1, 1'b0, 1'b0, 1'b0);
      step("R9", 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0);
      status("R9");
      // R5 R11 R7: wrong first key, then everything ignored
      step("R5", 1'b1, 8'h12, 1'b0, 1'b0, 1'b0);
      status("R11");
      step("R7", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      step("R7", 1'b1, 8'hF1, 1'b0, 1'b0, 1'b0);
      step("R7", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
      idle("R7", 3);
      status("R7");
      // R5: keys reversed
      do_reset();
      step("R5", 1'b1, 8'hF1, 1'b0, 1'b0, 1'b0);
      status("R5");
      // R5: first key twice
      do_reset();
      step("R2", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      step("R5", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      status("R5");
      // R5: wrong second key
      do_reset();
      step("R2", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      step("R5", 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0);
      status("R5");
      // R6: access while locked
      do_reset();
      step("R6", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      status("R6");
      // R6: read access after the first key
      do_reset();
      step("R2", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      step("R6", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
      status("R6");
      // R6: key write and access in the same cycle
      do_reset();
      step("R6", 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0);
      status("R6");
      idle("R11", 2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule